// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer with Precharge Scheduling

This block drives the command pins, bank select, address and data-mask lines of a two-bank SDRAM through one write burst of four beats. It then closes the bank with a precharge. The row is assumed to be open already. A request carries the target bank, the column, all four data beats and a mode flag. In finish mode every beat is stored, and the bank is precharged once the two-cycle write-recovery gap has passed. In truncate mode the precharge is issued at a chosen beat, and that beat and every later beat of the burst are masked.

Commands appear on the pins as the 4-bit value {cs_n, ras_n, cas_n, we_n}: WRITE = 0100, PRECHARGE = 0010 and NOP = 0111. The cycle in which WRITE appears is called W. The write timing does not depend on the CAS latency parameter. That parameter only accepts the values 2 and 3.

Top module: `sdram_wr_pre_seq`

## Requirements
- R1: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. In the next cycle (W) the pins show WRITE. In that cycle sd_addr_o[7:0] carries the column, A10 (sd_addr_o[10]) and all other address bits are 0, sd_dq_oe_o is 1, sd_dqm_o is 0, and sd_dq_o carries beat 0 (req_data_i[15:0]).
- R2: Beats 1, 2 and 3 (req_data_i[16n+15:16n]) are driven in cycles W+1, W+2 and W+3 with sd_dq_oe_o high. sd_dqm_o stays low for every beat that is not masked under R4.
- R3: In finish mode, PRECHARGE is issued at W+5, which is two cycles after the last beat. sd_addr_o is all zero in that cycle, so A10 is low. Cycles W+4 and W+6 onward carry NOP.
- R4: In truncate mode with cut index k in 1..3, PRECHARGE is issued at W+k. sd_dqm_o is high from W+k through W+3. Beats before W+k are unmasked.
- R5: A truncate request with cut index 0 or 4..7 behaves exactly like finish mode.
- R6: done_o is high for exactly the one cycle that carries PRECHARGE.
- R7: req_ready_o is low from W until the last cycle of the sequence: W+5 in finish mode, W+3 in truncate mode. It is high in the following cycle, where a new request may be accepted at once. A request presented while req_ready_o is low has no effect on any output.
- R8: Outside a sequence the pins show NOP. In that state sd_ba_o, sd_addr_o, sd_dq_o, sd_dq_oe_o, sd_dqm_o and done_o are all 0, and req_ready_o is 1. This is also the state after reset.
- R9: sd_ba_o equals the bank of the accepted request, 0 or 1, in every cycle from W to the end of the sequence. The precharge therefore always targets the bank that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_bank_i | input | 1 | Target bank |
| req_col_i | input | 8 | Start column |
| req_trunc_i | input | 1 | 1 = truncate mode, 0 = finish mode |
| req_cut_i | input | 3 | Beat index at which truncation precharges |
| req_data_i | input | 64 | Four 16-bit beats, beat 0 in the low bits |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 1 | Bank address |
| sd_addr_o | output | 12 | Address, A10 in bit 10 |
| sd_dq_o | output | 16 | Write data |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dqm_o | output | 1 | Data mask |
| done_o | output | 1 | Pulses with the precharge |

## Verification
The assertions rely on reset being asserted before the first request. They take the request fields into account only on the accepting edge, and they expect the captured cut index to alter timing only when it lies in 1..3. The stimulus changes inputs on falling edges only. It presents requests in ready cycles, including back-to-back right after a sequence ends. It makes one deliberate request during a busy period to show that such a request is ignored. The cut indices span 0 through 7, so both the truncation slots and the out-of-range values that fall back to finish mode are covered.

// File: rtl/sdram_wseq_pkg.sv
package sdram_wseq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_WRITE = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111
  } cmd_e;
endpackage

// File: rtl/wseq_ctrl.sv
module wseq_ctrl #(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 3,
  parameter int CUT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_trunc_i,
  input  logic [CUT_W-1:0] req_cut_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] pre_at_o,
  output logic             trunc_o,
  output logic [CUT_W-1:0] cut_o
);
  localparam int TWR     = 2;
  localparam int FIN_PRE = BURST_LEN - 1 + TWR;

  logic             busy_q, trunc_q, cut_ok;
  logic [CNT_W-1:0] cyc_q, pre_at_q, last;
  logic [CUT_W-1:0] cut_q;

  assign accept_o = req_valid_i && !busy_q;
  assign cut_ok   = (req_cut_i != '0) && (int'(req_cut_i) < BURST_LEN);
  // sequence ends at the later of last beat and precharge slot
  assign last     = (int'(pre_at_q) > BURST_LEN - 1) ? pre_at_q : CNT_W'(BURST_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      trunc_q  <= 1'b0;
      cyc_q    <= '0;
      pre_at_q <= '0;
      cut_q    <= '0;
    end else if (accept_o) begin
      busy_q   <= 1'b1;
      cyc_q    <= '0;
      trunc_q  <= req_trunc_i && cut_ok;
      cut_q    <= req_cut_i;
      pre_at_q <= (req_trunc_i && cut_ok) ? CNT_W'(req_cut_i) : CNT_W'(FIN_PRE);
    end else if (busy_q) begin
      cyc_q <= cyc_q + 1'b1;
      if (cyc_q == last) busy_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign cyc_o    = cyc_q;
  assign pre_at_o = pre_at_q;
  assign trunc_o  = trunc_q;
  assign cut_o    = cut_q;

  // R4: a captured truncation slot always lies inside the burst
  a_r4_cut_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && trunc_q) |-> (pre_at_q != '0 && int'(pre_at_q) < BURST_LEN));
  // R7: no request is taken while a sequence runs
  a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && cyc_q != '0) |-> $stable(pre_at_q));
endmodule

// File: rtl/wseq_cmd.sv
module wseq_cmd
  import sdram_wseq_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cyc_i,
  input  logic [CNT_W-1:0]  pre_at_i,
  output cmd_e              cmd_o,
  output logic              ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic             bank_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      col_q  <= '0;
    end else if (accept_i) begin
      bank_q <= req_bank_i;
      col_q  <= req_col_i;
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 1'b0;
    addr_o = '0;
    done_o = 1'b0;
    if (busy_i) begin
      ba_o = bank_q;
      if (cyc_i == '0) begin
        cmd_o               = CMD_WRITE;
        addr_o[COL_W-1:0]   = col_q;
      end else if (cyc_i == pre_at_i) begin
        cmd_o  = CMD_PRE;
        done_o = 1'b1;
      end
    end
    addr_o[AP_BIT] = 1'b0; // single-bank precharge, no auto-precharge
  end

  // R6: one precharge per sequence
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/wseq_data.sv
module wseq_data #(
  parameter int BURST_LEN = 4,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3,
  parameter int CUT_W     = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          accept_i,
  input  logic [BURST_LEN*DATA_W-1:0]   req_data_i,
  input  logic                          busy_i,
  input  logic [CNT_W-1:0]              cyc_i,
  input  logic                          trunc_i,
  input  logic [CUT_W-1:0]              cut_i,
  output logic [DATA_W-1:0]             dq_o,
  output logic                          dq_oe_o,
  output logic                          dqm_o
);
  localparam int BIDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [DATA_W-1:0] beat_q [BURST_LEN];
  logic              in_burst;

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       beat_q[b] <= '0;
      else if (accept_i) beat_q[b] <= req_data_i[b*DATA_W +: DATA_W];
    end
  end

  assign in_burst = busy_i && (int'(cyc_i) < BURST_LEN);
  assign dq_oe_o  = in_burst;
  assign dq_o     = in_burst ? beat_q[cyc_i[BIDX_W-1:0]] : '0;
  // mask from the precharge beat to the nominal burst end
  assign dqm_o    = in_burst && trunc_i && (int'(cyc_i) >= int'(cut_i));

  // R4: once masking starts it holds to the end of the beats
  a_r4_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqm_o && int'(cyc_i) < BURST_LEN - 1) |=> dqm_o);
endmodule

// File: rtl/sdram_wr_pre_seq.sv
module sdram_wr_pre_seq
  import sdram_wseq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int DATA_W    = 16,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int CAS_LAT   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_bank_i,
  input  logic [COL_W-1:0]            req_col_i,
  input  logic                        req_trunc_i,
  input  logic [$clog2(BURST_LEN):0]  req_cut_i,
  input  logic [BURST_LEN*DATA_W-1:0] req_data_i,
  output logic                        sd_cs_n_o,
  output logic                        sd_ras_n_o,
  output logic                        sd_cas_n_o,
  output logic                        sd_we_n_o,
  output logic                        sd_ba_o,
  output logic [ADDR_W-1:0]           sd_addr_o,
  output logic [DATA_W-1:0]           sd_dq_o,
  output logic                        sd_dq_oe_o,
  output logic                        sd_dqm_o,
  output logic                        done_o
);
  localparam int CUT_W = $clog2(BURST_LEN) + 1;
  localparam int CNT_W = $clog2(BURST_LEN + 2);

  // write timing is latency-independent; only legal latencies are accepted
  if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_cl
    $error("CAS_LAT must be 2 or 3");
  end

  logic             busy, accept, trunc;
  logic [CNT_W-1:0] cyc, pre_at;
  logic [CUT_W-1:0] cut;
  cmd_e             cmd;

  wseq_ctrl #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .CUT_W(CUT_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_trunc_i, .req_cut_i,
    .busy_o(busy), .accept_o(accept), .cyc_o(cyc), .pre_at_o(pre_at),
    .trunc_o(trunc), .cut_o(cut)
  );

  wseq_cmd #(.CNT_W(CNT_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_cmd (
    .clk_i, .rst_ni, .accept_i(accept), .req_bank_i, .req_col_i,
    .busy_i(busy), .cyc_i(cyc), .pre_at_i(pre_at),
    .cmd_o(cmd), .ba_o(sd_ba_o), .addr_o(sd_addr_o), .done_o
  );

  wseq_data #(.BURST_LEN(BURST_LEN), .DATA_W(DATA_W), .CNT_W(CNT_W), .CUT_W(CUT_W)) u_data (
    .clk_i, .rst_ni, .accept_i(accept), .req_data_i,
    .busy_i(busy), .cyc_i(cyc), .trunc_i(trunc), .cut_i(cut),
    .dq_o(sd_dq_o), .dq_oe_o(sd_dq_oe_o), .dqm_o(sd_dqm_o)
  );

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
  assign req_ready_o = !busy;

  // R1: write command carries unmasked beat 0
  a_r1_write_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_WRITE) |-> (sd_dq_oe_o && !sd_dqm_o));
  // R3: finish mode precharges two cycles after the last beat
  a_r3_finish_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_dq_oe_o && cyc == CNT_W'(BURST_LEN - 1) && !trunc) |-> ##2 (cmd == CMD_PRE));
  // R4: a precharge inside the burst masks its beat
  a_r4_mask_at_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE && sd_dq_oe_o) |-> sd_dqm_o);
  // R8: idle pins
  a_r8_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cmd == CMD_NOP && !sd_dq_oe_o && !sd_dqm_o && !done_o));
  // R9: bank held through the sequence
  a_r9_bank_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && cyc != '0) |-> $stable(sd_ba_o));
endmodule

// File: tb/tb_sdram_wr_pre_seq.sv
`timescale 1ns/1ps
module tb_sdram_wr_pre_seq;
  typedef struct packed {
    logic        bank;
    logic [7:0]  col;
    logic        trunc;
    logic [2:0]  cut;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h12, 1'b0, 3'd0, 16'h1000},
    '{1'b1, 8'h34, 1'b0, 3'd2, 16'h2345},
    '{1'b0, 8'h56, 1'b1, 3'd1, 16'h3a5c},
    '{1'b1, 8'h78, 1'b1, 3'd2, 16'h4b6d},
    '{1'b0, 8'h9a, 1'b1, 3'd3, 16'h5c7e},
    '{1'b1, 8'hbc, 1'b1, 3'd0, 16'h6d8f},
    '{1'b0, 8'hde, 1'b1, 3'd4, 16'h7e90},
    '{1'b1, 8'hf0, 1'b1, 3'd7, 16'h8fa1}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_bank = 1'b0, req_trunc = 1'b0;
  logic [7:0]  req_col = '0;
  logic [2:0]  req_cut = '0;
  logic [63:0] req_data = '0;
  logic        req_ready, cs_n, ras_n, cas_n, we_n, ba, dq_oe, dqm, done;
  logic [11:0] addr;
  logic [15:0] dq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_wr_pre_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_col_i(req_col), .req_trunc_i(req_trunc),
    .req_cut_i(req_cut), .req_data_i(req_data),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr), .sd_dq_o(dq), .sd_dq_oe_o(dq_oe),
    .sd_dqm_o(dqm), .done_o(done)
  );

  function automatic logic [15:0] beat(input logic [15:0] seed, input int n);
    return seed ^ (16'(n) * 16'h1111);
  endfunction

  function automatic logic [36:0] pins();
    return {cs_n, ras_n, cas_n, we_n, ba, addr, dq_oe, dqm, dq, done, req_ready};
  endfunction

  task automatic compare(input logic [36:0] exp, input string tag);
    n_chk++;
    if (pins() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, pins(), exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    compare({4'b0111, 1'b0, 12'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1}, tag);
  endtask

  // expected pins in cycle W+n of a sequence for request v
  task automatic chk_cycle(input vec_t v, input int n);
    logic        eff;
    int          pre, last;
    logic [3:0]  cmd;
    logic [11:0] a;
    logic        m, oe, in_seq;
    string       tag;
    eff    = v.trunc && v.cut >= 1 && v.cut <= 3;   // R5
    pre    = eff ? int'(v.cut) : 5;
    last   = eff ? 3 : 5;
    in_seq = n <= last;
    oe     = n < 4;
    m      = eff && n >= int'(v.cut) && n < 4;
    cmd    = (n == 0) ? 4'b0100 : (n == pre) ? 4'b0010 : 4'b0111;
    a      = (n == 0) ? {4'h0, v.col} : 12'h0;
    if (n == 0)            tag = "R1 R9";
    else if (n == pre)     tag = eff ? "R4 R6" : "R3 R6";
    else if (m)            tag = "R4";
    else if (n > last)     tag = "R7";
    else if (oe)           tag = "R2";
    else                   tag = "R3";
    if (v.trunc && !eff)   tag = {tag, " R5"};
    compare({cmd, in_seq ? v.bank : 1'b0, a, oe, m, oe ? beat(v.seed, n) : 16'h0,
             n == pre, !in_seq}, tag);
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    req_bank  = v.bank;
    req_col   = v.col;
    req_trunc = v.trunc;
    req_cut   = v.cut;
    for (int b = 0; b < 4; b++) req_data[b*16 +: 16] = beat(v.seed, b);
  endtask

  // entered and left at a falling edge; request driven at once
  task automatic run_vec(input vec_t v);
    int last;
    last = (v.trunc && v.cut >= 1 && v.cut <= 3) ? 3 : 5;
    drive(v);
    for (int n = 0; n <= last + 1; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      chk_cycle(v, n);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t a, b;
    repeat (3) @(negedge clk);
    chk_idle("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R8 R7 idle");

    // table walk, requests back-to-back
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);
    @(negedge clk);
    chk_idle("R8 after table");

    // request while busy must be ignored (R7)
    a = '{1'b0, 8'h11, 1'b0, 3'd0, 16'hc3c3};
    b = '{1'b1, 8'h22, 1'b1, 3'd1, 16'h0f0f};
    drive(a);
    @(negedge clk);
    chk_cycle(a, 0);
    drive(b);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n == 4) req_valid = 1'b0;
      chk_cycle(a, n);
    end
    @(negedge clk);
    chk_idle("R7 busy request dropped");

    // truncate at the last beat, then finish on the other bank (R4 R9)
    run_vec('{1'b1, 8'h01, 1'b1, 3'd3, 16'hffff});
    run_vec('{1'b0, 8'hff, 1'b0, 3'd7, 16'h0000});
    @(negedge clk);
    chk_idle("R8 end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule